// File: doc/BRIEF.md
# Configurable-format serial transmitter

This block turns bytes handed over by a host into asynchronous serial frames on a single output line. The host presents a byte with a one-cycle load strobe. The byte sits in a holding register until the frame engine is free. It then moves into a shift register, and the host may write the next byte at once. A buffer-empty flag shows the host when the holding register can take another byte.

A 3-bit format code picks one of eight word layouts: 7 or 8 data bits, no parity or even or odd parity, and one or two stop bits. The timing comes from an external enable pulse that runs at a multiple of the bit rate. The block counts a fixed number of these pulses for every bit. The format code is read at the moment a frame starts, so changing it never corrupts a frame already in progress.

Top module: `sertx_frame`

## Requirements
- R1: The line idles high. Each frame opens with one low start bit, and the data bits follow least significant bit first.
- R2: Format codes 000 and 001 send data bits 0..6 (input bit 7 is not sent), then a parity bit (even for 000, odd for 001), then two high stop bits. The frame is 11 bits long.
- R3: Format codes 010 and 011 send data bits 0..6, then a parity bit (even for 010, odd for 011), then one stop bit. The frame is 10 bits long.
- R4: Format codes 100 and 101 send all 8 data bits with no parity bit, followed by two stop bits (100) or one stop bit (101).
- R5: Format codes 110 and 111 send all 8 data bits, then a parity bit (even for 110, odd for 111), then one stop bit. Even parity makes the count of ones in the data and parity bits even; odd parity makes it odd.
- R6: Every bit of a frame, including the start bit, lasts exactly 16 enable pulses. Within a frame the line changes only at the clock edge that takes the 16th pulse of a bit.
- R7: A load strobe captures the input byte into the holding register, and buffer-empty reads low from the next cycle. A load while the holding register is already full replaces the held byte.
- R8: When the frame engine is idle and the holding register is full, the byte moves into the shift register at the next clock edge. Buffer-empty rises and the start bit begins at that same edge. While a frame runs, a held byte waits and buffer-empty stays low, and that byte's frame follows the current one with a gap of one cycle.
- R9: The format code is taken when a frame starts. A change during a frame applies only from the next frame on.
- R10: A load strobe in the same cycle as the move into the shift register keeps the new byte in the holding register. Buffer-empty stays low, and that byte is sent as the next frame.
- R11: A synchronous active-high reset drives the line high and buffer-empty high. It aborts any frame in progress and discards a held byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Enable pulse at 16 times the bit rate |
| load | input | 1 | Strobe that captures `din` into the holding register |
| din | input | 8 | Byte to transmit |
| fmt | input | 3 | Word format code, sampled at frame start |
| line_out | output | 1 | Serial output line |
| buf_empty | output | 1 | High when the holding register can take a new byte |

## Verification
The collision that matters here is a host load that lands on the same clock edge as the move of the held byte into the shift register. There, clearing the holding register and filling it compete. The bench provokes it by strobing two bytes on consecutive cycles into an idle block: the second strobe meets the edge at which the first byte starts its frame. It judges the outcome by buffer-empty staying low after that edge and by the scoreboard receiving both frames, in order and intact. A related case, a load landing while a frame is still shifting, is provoked with a held byte that is overwritten before the frame ends. Only the last byte may appear on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;
    localparam int LEN_W   = 4;

    typedef struct packed {
        logic seven;
        logic parity;
        logic odd;
        logic two_stop;
    } fmt_fields_t;

    function automatic fmt_fields_t decode_fmt(input logic [2:0] code);
        fmt_fields_t f;
        f.seven    = ~code[2];
        f.parity   = ~code[2] | code[1];
        f.odd      = code[0];
        f.two_stop = (~code[2] & ~code[1]) | (code[2] & ~code[1] & ~code[0]);
        return f;
    endfunction

endpackage

// File: rtl/sertx_fmt_decode.sv
module sertx_fmt_decode
    import sertx_pkg::*;
(
    input  logic [DATA_W-1:0]  data_i,
    input  logic [2:0]         code_i,
    output logic [FRAME_W-1:0] bits_o,
    output logic [LEN_W-1:0]   len_o
);

    fmt_fields_t       f;
    int                nd;
    logic [DATA_W-1:0] mask;
    logic              par;

    always_comb begin
        f    = decode_fmt(code_i);
        nd   = f.seven ? DATA_W - 1 : DATA_W;
        mask = f.seven ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
        par  = (^(data_i & mask)) ^ f.odd;

        bits_o    = '1;
        bits_o[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) bits_o[1+i] = data_i[i];
        end
        if (f.parity) bits_o[1+nd] = par;

        len_o = LEN_W'(1 + nd + (f.parity ? 1 : 0) + (f.two_stop ? 2 : 1));
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) st_d.full = 1'b0;
        if (load_i) begin
            st_d.data = data_i;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               ready_i,
    input  logic [FRAME_W-1:0] bits_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               take_o,
    output logic               line_o
);

    localparam int SUB_W = $clog2(TICKS_PER_BIT);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [LEN_W-1:0]   left;
        logic [SUB_W-1:0]   sub;
    } shift_st_t;

    shift_st_t st_d, st_q;

    assign take_o = ~st_q.busy & ready_i;

    always_comb begin
        st_d = st_q;
        if (take_o) begin
            st_d.busy  = 1'b1;
            st_d.frame = bits_i;
            st_d.left  = len_i;
            st_d.sub   = '0;
        end else if (st_q.busy && tick_i) begin
            if (st_q.sub == SUB_LAST) begin
                st_d.sub   = '0;
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == LEN_W'(1)) st_d.busy = 1'b0;
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign line_o = st_q.busy ? st_q.frame[0] : 1'b1;

    // R1: a frame starts with a low line
    a_r1_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.busy) |-> !line_o);

    // R6: the line holds unless the last pulse of a bit is taken
    a_r6_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !(tick_i && st_q.sub == SUB_LAST)) |=> $stable(line_o));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        fmt,
    output logic              line_out,
    output logic              buf_empty
);

    logic [DATA_W-1:0]  held;
    logic               full;
    logic               take;
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;

    sertx_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .data_i (din),
        .take_i (take),
        .data_o (held),
        .full_o (full)
    );

    sertx_fmt_decode u_dec (
        .data_i (held),
        .code_i (fmt),
        .bits_o (bits),
        .len_o  (len)
    );

    sertx_shift #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (bit_tick),
        .ready_i (full),
        .bits_i  (bits),
        .len_i   (len),
        .take_o  (take),
        .line_o  (line_out)
    );

    assign buf_empty = ~full;

    // R7: a load fills the holding register
    a_r7_load_fills: assert property (@(posedge clk) disable iff (rst)
        load |=> !buf_empty);

    // R8: moving the byte out empties the holding register
    a_r8_empty_on_take: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> buf_empty);

    // R10: a load on the move edge keeps the register full
    a_r10_load_on_take: assert property (@(posedge clk) disable iff (rst)
        (take && load) |=> !buf_empty);

    // R11: reset returns the line and buffer to idle
    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (line_out && buf_empty));

endmodule

// File: tb/sertx_frame_tb_top.sv
module sertx_frame_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] din = 8'h00;
    logic [2:0] fmt = 3'b000;
    logic       line_out;
    logic       buf_empty;

    always #10 clk = ~clk;

    sertx_frame dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .load      (load),
        .din       (din),
        .fmt       (fmt),
        .line_out  (line_out),
        .buf_empty (buf_empty)
    );

    typedef struct {
        logic [11:0] bits;
        int          len;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   cycles   = 0;
    bit   mon_active = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string fmt_tag(input logic [2:0] f);
        if (!f[2]) return f[1] ? "R3" : "R2";
        return f[1] ? "R5" : "R4";
    endfunction

    function automatic exp_t make_exp(input logic [7:0] d, input logic [2:0] f,
                                      input string tag);
        exp_t e;
        int nd   = f[2] ? 8 : 7;
        bit usep = !f[2] || f[1];
        int ns   = (f == 3'd0 || f == 3'd1 || f == 3'd4) ? 2 : 1;
        int ones = 0;
        int pos  = 0;
        e.bits = 12'hFFF;
        e.bits[pos] = 1'b0; pos++;
        for (int i = 0; i < nd; i++) begin
            e.bits[pos] = d[i]; pos++;
            if (d[i]) ones++;
        end
        if (usep) begin
            e.bits[pos] = f[0] ? ((ones % 2) == 0) : ((ones % 2) == 1);
            pos++;
        end
        for (int i = 0; i < ns; i++) begin
            e.bits[pos] = 1'b1; pos++;
        end
        e.len = pos;
        e.tag = tag;
        return e;
    endfunction

    // enable pulse every fourth cycle
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            bit_tick <= 1'b1;
            @(posedge clk);
            bit_tick <= 1'b0;
        end
    end

    // monitor: decodes frames on the line and compares them with the queue
    exp_t cur;
    int   tcnt;
    int   bad_idx;
    bit   prev_line = 1'b1;
    always @(negedge clk) begin
        if (rst) begin
            mon_active = 1'b0;
            prev_line  = 1'b1;
        end else begin
            if (!mon_active && prev_line && !line_out) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "unexpected frame start", 1, 0);
                end else begin
                    cur = q.pop_front();
                    mon_active = 1'b1;
                    tcnt = 0;
                    bad_idx = -1;
                end
            end
            if (mon_active && bit_tick) begin
                tcnt++;
                if (tcnt == 16)
                    check(line_out == 1'b0, "R6", "start bit before 16th pulse",
                          int'(line_out), 0);
                if ((tcnt % 16) == 8) begin
                    if (line_out !== cur.bits[tcnt/16] && bad_idx < 0)
                        bad_idx = tcnt / 16;
                end
                if (tcnt == 16 * cur.len) begin
                    if (bad_idx >= 0)
                        check(1'b0, cur.tag, $sformatf("frame bit %0d", bad_idx),
                              int'(!cur.bits[bad_idx]), int'(cur.bits[bad_idx]));
                    else
                        check(1'b1, cur.tag, "frame", 0, 0);
                    mon_active = 1'b0;
                end
            end
            prev_line = line_out;
        end
    end

    task automatic do_load(input logic [7:0] d, input logic [2:0] f,
                           input bit push, input string tag, input bit idle_chk);
        @(posedge clk);
        fmt  <= f;
        din  <= d;
        load <= 1'b1;
        if (push) q.push_back(make_exp(d, f, tag == "" ? fmt_tag(f) : tag));
        @(posedge clk);
        load <= 1'b0;
        if (idle_chk) begin
            @(negedge clk);
            check(buf_empty == 1'b0, "R7", "buf_empty after load", int'(buf_empty), 0);
            @(negedge clk);
            check(buf_empty == 1'b1, "R8", "buf_empty after move", int'(buf_empty), 1);
            check(line_out == 1'b0, "R8", "start bit after move", int'(line_out), 0);
        end
    endtask

    task automatic wait_idle();
        wait (q.size() == 0 && !mon_active && buf_empty);
        repeat (8) @(posedge clk);
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] pat [8];
        pat[0] = 8'hB5; pat[1] = 8'hC3; pat[2] = 8'h97; pat[3] = 8'hE1;
        pat[4] = 8'h5B; pat[5] = 8'h3D; pat[6] = 8'h6F; pat[7] = 8'h81;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(line_out == 1'b1, "R11", "line in reset", int'(line_out), 1);
        check(buf_empty == 1'b1, "R11", "buf_empty in reset", int'(buf_empty), 1);
        @(posedge clk);
        rst <= 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(line_out == 1'b1, "R1", "idle line", int'(line_out), 1);

        // every format, one frame each
        for (int f = 0; f < 8; f++) begin
            do_load(pat[f], 3'(f), 1'b1, "", 1'b1);
            wait_idle();
        end

        // R8: second byte waits while the first is shifting
        do_load(8'h4E, 3'd5, 1'b1, "R8", 1'b1);
        do_load(8'hA3, 3'd5, 1'b1, "R8", 1'b0);
        repeat (100) @(posedge clk);
        @(negedge clk);
        check(buf_empty == 1'b0, "R8", "held byte during frame", int'(buf_empty), 0);
        wait_idle();

        // R7: a held byte is overwritten before it is sent
        do_load(8'h71, 3'd7, 1'b1, "R7", 1'b1);
        do_load(8'h22, 3'd7, 1'b0, "", 1'b0);
        repeat (30) @(posedge clk);
        do_load(8'hD9, 3'd7, 1'b1, "R7", 1'b0);
        wait_idle();

        // R10: load on the same edge as the move into the shift register
        @(posedge clk);
        fmt  <= 3'd6;
        din  <= 8'h35;
        load <= 1'b1;
        q.push_back(make_exp(8'h35, 3'd6, "R10"));
        @(posedge clk);
        din  <= 8'hCA;
        q.push_back(make_exp(8'hCA, 3'd6, "R10"));
        @(posedge clk);
        load <= 1'b0;
        @(negedge clk);
        check(buf_empty == 1'b0, "R10", "buf_empty after collision", int'(buf_empty), 0);
        check(line_out == 1'b0, "R10", "first frame started", int'(line_out), 0);
        wait_idle();

        // R9: format change during a frame applies to the next frame only
        do_load(8'hB7, 3'd0, 1'b1, "R9", 1'b1);
        repeat (40) @(posedge clk);
        do_load(8'h4D, 3'd6, 1'b1, "R9", 1'b0);
        wait_idle();

        // R11: reset mid-frame with a byte held
        do_load(8'h99, 3'd4, 1'b1, "R11", 1'b1);
        repeat (200) @(posedge clk);
        do_load(8'h66, 3'd4, 1'b0, "", 1'b0);
        repeat (10) @(posedge clk);
        rst <= 1'b1;
        repeat (2) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        check(line_out == 1'b1, "R11", "line after reset", int'(line_out), 1);
        check(buf_empty == 1'b1, "R11", "buf_empty after reset", int'(buf_empty), 1);
        q.delete();
        repeat (1500) @(posedge clk);
        @(negedge clk);
        check(!mon_active && line_out == 1'b1, "R11", "no frame after reset",
              int'(mon_active), 0);

        check(q.size() == 0, "R8", "frames left in queue", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule